// File: doc/BRIEF.md
# Card Bus Cycle Phase Timer

This block times the three phases of one access on a card bus: an address setup phase, a command strobe phase and a recovery phase. All lengths are counted in clocks of the block's own clock. The host raises a start request and picks one of two timer sets with a select bit. The block then raises a setup flag, a command strobe and a recovery flag in turn, each for a time taken from that set's programmable registers. A one-clock done pulse marks the end of the access.

Each timer set has three byte-wide registers, one each for setup, command and recovery. In each register a two-bit field picks a prescaler and a six-bit field holds a multiplier. A phase lasts prescaler times multiplier plus one clock. The registers are written and read back through a small byte-wide register port. When a cycle is accepted, the block takes a snapshot of the selected set, so register writes made during an access only affect later accesses.

Top module: `cardPhaseTimer`

## Requirements
- R1: Six byte registers answer on the register port: set 0 setup, command and recovery at addresses 3Ah, 3Bh and 3Ch, and set 1 setup, command and recovery at 3Dh, 3Eh and 3Fh. A write takes effect at the clock edge where regWrEn is high. regRdData shows the addressed register combinationally and reads 00h at any other address. Writes to other addresses change nothing.
- R2: After reset, the setup, command and recovery registers of both sets hold 01h, 06h and 03h. With no writes, a set-0 cycle therefore lasts 2, 7 and 4 clocks.
- R3: In every register, bits 7:6 select the prescaler (00 = 1, 01 = 16, 10 = 256, 11 = 4096) and bits 5:0 hold the multiplier. A phase lasts prescaler × multiplier + 1 clocks.
- R4: The phases always run setup, then command, then recovery. While a cycle runs, exactly one of setupActive, cmdActive and recovActive is high. When idle, none is high.
- R5: setupActive stays high for the length given by the selected set's setup register, starting in the clock after the edge that accepts cycStart.
- R6: cmdActive stays high for the length given by the selected set's command register, directly after setup.
- R7: recovActive stays high for the length given by the selected set's recovery register, directly after command.
- R8: A multiplier of 0 gives a phase of exactly one clock, whatever the prescaler.
- R9: setSel = 0 selects set 0 and setSel = 1 selects set 1. It is sampled only at the edge that accepts cycStart.
- R10: A register write made while a cycle runs does not change the length of any phase of that cycle. It applies from the next accepted cycle.
- R11: cycStart is ignored while a cycle runs. No second cycle follows the current one unless cycStart is raised after it.
- R12: cycDone is high for exactly one clock, the clock after the last recovery clock. A cycStart in that clock is accepted, and setupActive rises in the next clock with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all phase lengths count its periods |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address for writes and reads |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Contents of the addressed register |
| cycStart | input | 1 | Request to start a cycle |
| setSel | input | 1 | Timer set for the requested cycle |
| setupActive | output | 1 | High during the address setup phase |
| cmdActive | output | 1 | Command strobe, high during the command phase |
| recovActive | output | 1 | High during the recovery phase |
| cycDone | output | 1 | One-clock pulse at the end of a cycle |

## Verification
The bench targets phase lengths at the edges of the encoding.

- A zero multiplier must still give one clock; a counter that treats zero as wrap-around or as "no phase" would skip the phase or run for a very long time.
- The largest prescaler must give 4097 clocks; a counter that is too narrow would truncate it.
- Each prescaler code is compared against its own value, so a swapped pair of codes shows up as a wrong length.

The bench also writes the next phase's register in the middle of a cycle. A design that reads live registers instead of a snapshot would stretch or shrink that cycle.

Two further cases cover cycle boundaries:
- A start request raised during the command phase must be dropped. A design that queues it would launch an unrequested cycle.
- A start in the done clock must be taken at once. A design that needs an extra idle clock would show a one-clock gap before setup.

// File: rtl/cptPkg.sv
package cptPkg;
  localparam int CODE_W     = 8;
  localparam int MULT_W     = 6;
  localparam int PRES_STEP  = 4;
  localparam int PRES_CODES = 4;
  localparam int PHASES     = 3;
  localparam int CNT_W      = MULT_W + PRES_STEP * (PRES_CODES - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_CMD, PH_RECOV} phaseE;

  typedef struct packed {
    logic loadSetup;
    logic loadCmd;
    logic loadRecov;
  } ctrlS;

  localparam logic [PHASES-1:0][CODE_W-1:0] RESET_CODES = {8'h03, 8'h06, 8'h01};

  function automatic logic [CNT_W-1:0] phaseTicks(input logic [CODE_W-1:0] code);
    logic [3:0] shiftAmt;
    shiftAmt = {code[CODE_W-1:CODE_W-2], 2'b00};
    return CNT_W'(code[MULT_W-1:0]) << shiftAmt;
  endfunction
endpackage

// File: rtl/cptRegFile.sv
module cptRegFile
  import cptPkg::*;
#(
  parameter int NUM_SETS = 2,
  parameter logic [7:0] BASE_ADDR = 8'h3A,
  localparam int REG_N = NUM_SETS * PHASES
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [7:0] addr,
  input  logic [CODE_W-1:0] wrData,
  output logic [CODE_W-1:0] rdData,
  output logic [REG_N-1:0][CODE_W-1:0] regVec
);
  logic [7:0] offset;
  logic hit;

  assign offset = addr - BASE_ADDR;
  assign hit = (addr >= BASE_ADDR) && (offset < 8'(REG_N));

  for (genvar g = 0; g < REG_N; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN) regVec[g] <= RESET_CODES[g % PHASES];
      else if (wrEn && hit && offset == 8'(g)) regVec[g] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < REG_N; i++)
      if (hit && offset == 8'(i)) rdData = regVec[i];
  end
endmodule

// File: rtl/cptDatapath.sv
module cptDatapath
  import cptPkg::*;
#(
  parameter int NUM_SETS = 2,
  localparam int REG_N = NUM_SETS * PHASES,
  localparam int SEL_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  ctrlS ctrl,
  input  logic [SEL_W-1:0] setSel,
  input  logic [REG_N-1:0][CODE_W-1:0] regVec,
  output logic cntZero
);
  logic [CODE_W-1:0] liveSetup, liveCmd, liveRecov;
  logic [CODE_W-1:0] snapCmd, snapRecov;
  logic [CNT_W-1:0] count;

  always_comb begin
    liveSetup = regVec[0];
    liveCmd   = regVec[1];
    liveRecov = regVec[2];
    for (int s = 0; s < NUM_SETS; s++)
      if (setSel == SEL_W'(s)) begin
        liveSetup = regVec[s*PHASES];
        liveCmd   = regVec[s*PHASES+1];
        liveRecov = regVec[s*PHASES+2];
      end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapCmd   <= '0;
      snapRecov <= '0;
    end else if (ctrl.loadSetup) begin
      snapCmd   <= liveCmd;
      snapRecov <= liveRecov;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else if (ctrl.loadSetup) count <= phaseTicks(liveSetup);
    else if (ctrl.loadCmd) count <= phaseTicks(snapCmd);
    else if (ctrl.loadRecov) count <= phaseTicks(snapRecov);
    else if (count != '0) count <= count - 1'b1;
  end

  assign cntZero = (count == '0);
endmodule

// File: rtl/cptControl.sv
module cptControl
  import cptPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cycStart,
  input  logic cntZero,
  output ctrlS ctrl,
  output phaseE phase,
  output logic done
);
  phaseE nextPhase;

  always_comb begin
    nextPhase = phase;
    ctrl = '0;
    unique case (phase)
      PH_IDLE: if (cycStart) begin
        nextPhase = PH_SETUP;
        ctrl.loadSetup = 1'b1;
      end
      PH_SETUP: if (cntZero) begin
        nextPhase = PH_CMD;
        ctrl.loadCmd = 1'b1;
      end
      PH_CMD: if (cntZero) begin
        nextPhase = PH_RECOV;
        ctrl.loadRecov = 1'b1;
      end
      PH_RECOV: if (cntZero) nextPhase = PH_IDLE;
      default: nextPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= nextPhase;
      done  <= (phase == PH_RECOV) && cntZero;
    end
  end
endmodule

// File: rtl/cardPhaseTimer.sv
module cardPhaseTimer
  import cptPkg::*;
#(
  parameter int NUM_SETS = 2,
  parameter logic [7:0] BASE_ADDR = 8'h3A,
  localparam int REG_N = NUM_SETS * PHASES,
  localparam int SEL_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic cycStart,
  input  logic [SEL_W-1:0] setSel,
  output logic setupActive,
  output logic cmdActive,
  output logic recovActive,
  output logic cycDone
);
  logic [REG_N-1:0][CODE_W-1:0] regVec;
  ctrlS ctrl;
  phaseE phase;
  logic cntZero;

  cptRegFile #(.NUM_SETS(NUM_SETS), .BASE_ADDR(BASE_ADDR)) i_regs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr),
    .wrData(regWrData), .rdData(regRdData), .regVec(regVec)
  );

  cptDatapath #(.NUM_SETS(NUM_SETS)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .setSel(setSel),
    .regVec(regVec), .cntZero(cntZero)
  );

  cptControl i_ctl (
    .clk(clk), .rstN(rstN), .cycStart(cycStart), .cntZero(cntZero),
    .ctrl(ctrl), .phase(phase), .done(cycDone)
  );

  assign setupActive = (phase == PH_SETUP);
  assign cmdActive   = (phase == PH_CMD);
  assign recovActive = (phase == PH_RECOV);
endmodule

// File: rtl/cptChecker.sv
module cptChecker (
  input logic clk,
  input logic rstN,
  input logic cycStart,
  input logic setupActive,
  input logic cmdActive,
  input logic recovActive,
  input logic cycDone
);
  // R4: at most one phase flag at a time
  p_one_phase_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({setupActive, cmdActive, recovActive}));

  // R4: setup hands over to command
  p_setup_to_cmd_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(setupActive) |-> cmdActive);

  // R4: command hands over to recovery
  p_cmd_to_recov_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdActive) |-> recovActive);

  // R12: recovery ends in a done pulse
  p_recov_to_done_r12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(recovActive) |-> cycDone);

  // R12: done lasts one clock
  p_done_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    cycDone |=> !cycDone);

  // R12: start while idle (including the done clock) is accepted
  p_idle_start_r12: assert property (@(posedge clk) disable iff (!rstN)
    (cycStart && !setupActive && !cmdActive && !recovActive) |=> setupActive);

  // R11: start during command or recovery does not restart setup
  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cycStart && (cmdActive || recovActive)) |=> !setupActive);
endmodule

bind cardPhaseTimer cptChecker i_chk (
  .clk(clk), .rstN(rstN), .cycStart(cycStart), .setupActive(setupActive),
  .cmdActive(cmdActive), .recovActive(recovActive), .cycDone(cycDone)
);

// File: tb/test_cardPhaseTimer.sv
module test_cardPhaseTimer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic cycStart = 1'b0;
  logic [0:0] setSel = 1'b0;
  logic setupActive, cmdActive, recovActive, cycDone;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cardPhaseTimer i_cardPhaseTimer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cycStart(cycStart),
    .setSel(setSel), .setupActive(setupActive), .cmdActive(cmdActive),
    .recovActive(recovActive), .cycDone(cycDone)
  );

  typedef struct packed {
    logic [7:0] sel, sc, cc, rc;
    logic [15:0] es, ec, er;
  } vecT;

  // R3 / R8 / R9 table: set, three codes, expected lengths
  localparam vecT VECS [5] = '{
    '{8'd0, 8'h01, 8'h06, 8'h03, 16'd2,    16'd7,  16'd4},
    '{8'd1, 8'h00, 8'hC0, 8'h40, 16'd1,    16'd1,  16'd1},
    '{8'd0, 8'h41, 8'h02, 8'h3F, 16'd17,   16'd3,  16'd64},
    '{8'd1, 8'h81, 8'h45, 8'h05, 16'd257,  16'd81, 16'd6},
    '{8'd0, 8'hC1, 8'h80, 8'h7F, 16'd4097, 16'd1,  16'd1009}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readChk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    chk(tag, int'(regRdData), int'(exp));
  endtask

  // Called at a negedge; returns at the negedge of the done clock.
  task automatic runCycle(input logic sel, output int s, output int c,
                          output int r, output int orderErr);
    int prevPh;
    int ph;
    int guard;
    s = 0; c = 0; r = 0; orderErr = 0; prevPh = 1; guard = 0;
    cycStart = 1'b1; setSel = sel;
    @(negedge clk);
    cycStart = 1'b0;
    while (!cycDone && guard < 20000) begin
      if (int'(setupActive) + int'(cmdActive) + int'(recovActive) != 1) orderErr++;
      ph = setupActive ? 1 : cmdActive ? 2 : recovActive ? 3 : 0;
      if (ph < prevPh) orderErr++;
      prevPh = ph;
      s += int'(setupActive); c += int'(cmdActive); r += int'(recovActive);
      guard++;
      @(negedge clk);
    end
    if (prevPh != 3) orderErr++;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int s, c, r, oe;
    repeat (3) @(negedge clk);
    // reset state
    chk("R4 idle flags after reset", int'({setupActive, cmdActive, recovActive}), 0);
    chk("R12 done low after reset", int'(cycDone), 0);
    rstN = 1'b1;
    @(negedge clk);
    readChk("R2 set0 setup", 8'h3A, 8'h01);
    readChk("R2 set0 cmd",   8'h3B, 8'h06);
    readChk("R2 set0 recov", 8'h3C, 8'h03);
    readChk("R2 set1 setup", 8'h3D, 8'h01);
    readChk("R2 set1 cmd",   8'h3E, 8'h06);
    readChk("R2 set1 recov", 8'h3F, 8'h03);
    readChk("R1 unmapped reads zero", 8'h40, 8'h00);

    // R1: writes to unmapped addresses leave registers unchanged
    writeReg(8'h39, 8'hAA);
    writeReg(8'h40, 8'h55);
    readChk("R1 write below range ignored", 8'h3A, 8'h01);
    readChk("R1 write above range ignored", 8'h3F, 8'h03);
    writeReg(8'h3E, 8'h5A);
    readChk("R1 write readback", 8'h3E, 8'h5A);
    writeReg(8'h3E, 8'h06);

    // R2: default set-0 cycle
    runCycle(1'b0, s, c, r, oe);
    chk("R2 default setup", s, 2);
    chk("R2 default cmd", c, 7);
    chk("R2 default recov", r, 4);
    chk("R4 default order", oe, 0);
    @(negedge clk);
    chk("R12 done one clock", int'(cycDone), 0);

    // R3 R5 R6 R7 R8 R9 table
    foreach (VECS[i]) begin
      logic [7:0] base;
      base = 8'h3A + 8'(VECS[i].sel * 3);
      writeReg(base, VECS[i].sc);
      writeReg(base + 8'd1, VECS[i].cc);
      writeReg(base + 8'd2, VECS[i].rc);
      runCycle(VECS[i].sel[0], s, c, r, oe);
      chk($sformatf("R5 R9 vec%0d setup", i), s, int'(VECS[i].es));
      chk($sformatf("R6 R8 vec%0d cmd", i), c, int'(VECS[i].ec));
      chk($sformatf("R7 R3 vec%0d recov", i), r, int'(VECS[i].er));
      chk($sformatf("R4 vec%0d order", i), oe, 0);
      @(negedge clk);
    end

    // R10: writes during a cycle do not affect it
    writeReg(8'h3A, 8'h01);
    writeReg(8'h3B, 8'h06);
    writeReg(8'h3C, 8'h03);
    fork
      runCycle(1'b0, s, c, r, oe);
      begin
        @(negedge clk);
        writeReg(8'h3B, 8'h10);
        writeReg(8'h3C, 8'h00);
        setSel = 1'b1;
      end
    join
    chk("R10 cmd kept", c, 7);
    chk("R10 recov kept", r, 4);
    @(negedge clk);
    runCycle(1'b0, s, c, r, oe);
    chk("R10 new cmd applies next", c, 17);
    chk("R10 new recov applies next", r, 1);
    @(negedge clk);

    // R11: start during a running cycle is ignored
    writeReg(8'h3C, 8'h03);
    fork
      runCycle(1'b0, s, c, r, oe);
      begin
        repeat (5) @(negedge clk);
        cycStart = 1'b1;
        @(negedge clk);
        cycStart = 1'b0;
      end
    join
    chk("R11 cycle length unchanged", s + c + r, 2 + 17 + 4);
    @(negedge clk);
    chk("R11 no extra cycle", int'(setupActive), 0);
    @(negedge clk);
    chk("R11 still idle", int'({setupActive, cmdActive, recovActive}), 0);

    // R12: start in the done clock is accepted at once
    runCycle(1'b0, s, c, r, oe);
    chk("R12 done seen", int'(cycDone), 1);
    cycStart = 1'b1; setSel = 1'b0;
    @(negedge clk);
    cycStart = 1'b0;
    chk("R12 back-to-back setup", int'(setupActive), 1);
    while (!cycDone) @(negedge clk);
    @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule